// File: doc/BRIEF.md
# Transmit Channel Shared Status and Error Register

This block gathers the state of eight transmit DMA channels into two readable words. The status word is live. For each channel it shows whether the channel's buffers are empty and whether the channel has no requests pending. After stopping a channel, software polls until both flags for that channel are set, which means the channel is idle.

The error word collects sticky fault flags from four sources:
- a credit check that the block runs itself: a FIFO-full strobe that arrives while the channel's credit counter is nonzero,
- a per-channel command overrun: an activation strobe that arrives while the channel's request buffer is still occupied,
- a host dword-count mismatch strobe,
- an internal address-error strobe.

Software clears an error flag by writing one to its bit. An interrupt output stays high while any error flag is set.

Register access uses a simple single-cycle port. Reads are combinational from the address. Writes take effect at the clock edge. Word address 0 is the status word, word address 1 is the error word, and every other address reads as zero.

Top module: `txs_shared_regs`

## Requirements
- R1: At address 0, bit 24+n of the read data equals channel n's buffer-empty input, bit 16+n equals channel n's no-pending input, and bits 15:0 read zero. The read follows the inputs in the same cycle.
- R2: A channel is idle when both of its flags are set. Both flags for every channel are visible in one read of address 0.
- R3: When channel n's FIFO-full strobe is high at a clock edge and its credit count is nonzero, error bit n (bits 7:0) reads 1 after that edge. With a zero credit count the strobe sets nothing.
- R4: When channel n's activation strobe is high at a clock edge and its request-buffer-busy input is high, error bit 9+n (bits 16:9) is set. An activation strobe while the buffer is free sets nothing.
- R5: A host dword-count mismatch strobe sets error bit 30.
- R6: An internal address-error strobe sets error bit 31.
- R7: An error bit stays set until a write to address 1 carries 1 in that bit position. Bits written as 0 are unchanged.
- R8: When a set event and a write-one clear hit the same bit on the same edge, the bit ends set.
- R9: The interrupt output is high exactly while the error word is nonzero.
- R10: Error bits 29:17 and bit 8 always read zero. Addresses 2 and 3 read zero. A write to address 0, 2 or 3 leaves the error word unchanged.
- R11: After reset the error word is zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_buf_empty | input | NUM_CH | Per-channel buffers-empty flag |
| ch_no_pend | input | NUM_CH | Per-channel no-requests-pending flag |
| ch_fifo_full | input | NUM_CH | Per-channel one-cycle FIFO-full strobe |
| ch_credit | input | NUM_CH*CREDIT_W | Per-channel credit counter, channel n in bits n*CREDIT_W upward |
| ch_act_cmd | input | NUM_CH | Per-channel DMA activation command strobe |
| ch_req_busy | input | NUM_CH | Per-channel request buffer holds a command |
| host_cnt_err | input | 1 | Host dword-count mismatch strobe |
| mem_addr_err | input | 1 | Internal memory address-error strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data, ones clear error bits |
| reg_rdata | output | 32 | Read data for reg_addr |
| err_irq | output | 1 | High while any error bit is set |

## Verification
The bench sweeps every channel against credit values of zero, one, a middle value and the maximum, and every channel against both states of the busy input.

The zero-credit case is aimed at a comparator that tests for full credit or ignores the counter. Such a design would either flag every FIFO-full strobe or miss real errors. A channel-index slip in the packing would show up as a flag on the neighbouring bit, including across the gap at bit 8.

Set-versus-clear collisions, writes of zero, and writes to the wrong address are each checked. A design where clear wins would lose a fresh error. A clear decoded without the address would wipe the word.

A full 256-pattern sweep of the status inputs is aimed at swapped or mis-shifted fields.

// File: rtl/txs_pkg.sv
// Package: shared constants for the transmit shared status/error register.
// Assumes a 32-bit register word and at most 8 channels, so the field positions
// below fit without overlap.
package txs_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned EMPTY_LSB = 24;  // buffer-empty flags in the status word
    localparam int unsigned PEND_LSB  = 16;  // no-pending flags in the status word
    localparam int unsigned CRED_LSB  = 0;   // credit error flags
    localparam int unsigned OVR_LSB   = 9;   // command overrun flags
    localparam int unsigned HOST_BIT  = 30;  // host dword-count mismatch
    localparam int unsigned ADDR_BIT  = 31;  // internal address error
    localparam int unsigned WA_STATUS = 0;   // word address of the status word
    localparam int unsigned WA_ERROR  = 1;   // word address of the error word
endpackage

// File: rtl/txs_chan_err.sv
// Module: per-channel error event detection.
// Turns each channel's strobes into error events: a credit error when FIFO-full
// arrives with a nonzero credit count, and an overrun when an activation command
// arrives while the request buffer is busy. Purely combinational. Assumes the
// strobes are single-cycle.
module txs_chan_err #(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned CREDIT_W = 8
) (
    input  logic [NUM_CH-1:0]          fifo_full,
    input  logic [NUM_CH*CREDIT_W-1:0] credit,
    input  logic [NUM_CH-1:0]          act_cmd,
    input  logic [NUM_CH-1:0]          req_busy,
    output logic [NUM_CH-1:0]          credit_ev,
    output logic [NUM_CH-1:0]          overrun_ev
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Purpose: flag a FIFO-full strobe that arrives with credit left over.
        always_comb credit_ev[i] = fifo_full[i] && (credit[i*CREDIT_W +: CREDIT_W] != '0);
        // Purpose: flag a new command that arrives onto an occupied request buffer.
        always_comb overrun_ev[i] = act_cmd[i] && req_busy[i];
    end
endmodule

// File: rtl/txs_sticky_w1c.sv
// Module: bank of sticky flags that software clears by writing one.
// A set on the same edge as a clear wins. Bits outside KEEP_MASK are tied to
// zero. Uses a synchronous active-low reset.
module txs_sticky_w1c #(
    parameter int unsigned          WIDTH     = 32,
    parameter logic [WIDTH-1:0]     KEEP_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] q
);
    // Purpose: hold flags, drop the ones cleared, then apply new sets on top.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~clr) | set) & KEEP_MASK;
    end

    AST_SET_WINS:   assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(set) & KEEP_MASK) == ($past(set) & KEEP_MASK))); // R8
    AST_STICKY:     assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(q & ~clr)) == $past(q & ~clr)));                 // R7
    AST_CLEARS:     assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(clr & ~set)) == '0));                           // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & ~$past(q) & ~$past(set)) == '0));                     // R3
endmodule

// File: rtl/txs_status_pack.sv
// Module: packs the live per-channel flags into the status word.
// Buffer-empty flags go from EMPTY_LSB upward and no-pending flags from
// PEND_LSB upward. All other bits are zero. Assumes NUM_CH <= 8.
module txs_status_pack
    import txs_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] buf_empty,
    input  logic [NUM_CH-1:0] no_pend,
    output logic [DATA_W-1:0] word
);
    // Purpose: place both flag fields into an otherwise zero word.
    always_comb begin
        word = '0;
        word[EMPTY_LSB +: NUM_CH] = buf_empty;
        word[PEND_LSB  +: NUM_CH] = no_pend;
    end
endmodule

// File: rtl/txs_shared_regs.sv
// Module: top of the transmit shared status and error register.
// It detects channel error events, latches them with the host and address
// strobes into a write-one-to-clear word, and serves the status and error words
// on a simple read/write port. It raises err_irq while any error is set.
// Assumes NUM_CH <= 8 and single-cycle event strobes. Reads are combinational.
module txs_shared_regs
    import txs_pkg::*;
#(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned CREDIT_W = 8,
    parameter int unsigned ADDR_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          ch_buf_empty,
    input  logic [NUM_CH-1:0]          ch_no_pend,
    input  logic [NUM_CH-1:0]          ch_fifo_full,
    input  logic [NUM_CH*CREDIT_W-1:0] ch_credit,
    input  logic [NUM_CH-1:0]          ch_act_cmd,
    input  logic [NUM_CH-1:0]          ch_req_busy,
    input  logic                       host_cnt_err,
    input  logic                       mem_addr_err,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_wr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic                       err_irq
);
    localparam logic [DATA_W-1:0] CH_ONES  = DATA_W'((64'd1 << NUM_CH) - 64'd1);
    localparam logic [DATA_W-1:0] ERR_MASK = (CH_ONES << CRED_LSB) | (CH_ONES << OVR_LSB)
                                           | (DATA_W'(1) << HOST_BIT) | (DATA_W'(1) << ADDR_BIT);

    logic [NUM_CH-1:0] credit_ev, overrun_ev;
    logic [DATA_W-1:0] set_vec, clr_vec, err_q, status_w;

    txs_chan_err #(.NUM_CH(NUM_CH), .CREDIT_W(CREDIT_W)) u_chan_err (
        .fifo_full (ch_fifo_full),
        .credit    (ch_credit),
        .act_cmd   (ch_act_cmd),
        .req_busy  (ch_req_busy),
        .credit_ev (credit_ev),
        .overrun_ev(overrun_ev)
    );

    txs_status_pack #(.NUM_CH(NUM_CH)) u_status (
        .buf_empty(ch_buf_empty),
        .no_pend  (ch_no_pend),
        .word     (status_w)
    );

    // Purpose: collect every error event into its bit position.
    always_comb begin
        set_vec = '0;
        set_vec[CRED_LSB +: NUM_CH] = credit_ev;
        set_vec[OVR_LSB  +: NUM_CH] = overrun_ev;
        set_vec[HOST_BIT] = host_cnt_err;
        set_vec[ADDR_BIT] = mem_addr_err;
    end

    // Purpose: write ones to the error word address clear the matching bits.
    always_comb clr_vec = (reg_wr && reg_addr == ADDR_W'(WA_ERROR)) ? reg_wdata : '0;

    txs_sticky_w1c #(.WIDTH(DATA_W), .KEEP_MASK(ERR_MASK)) u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set_vec),
        .clr  (clr_vec),
        .q    (err_q)
    );

    // Purpose: select the word addressed by reg_addr; unmapped addresses read zero.
    always_comb begin
        if (reg_addr == ADDR_W'(WA_STATUS))     reg_rdata = status_w;
        else if (reg_addr == ADDR_W'(WA_ERROR)) reg_rdata = err_q;
        else                                    reg_rdata = '0;
    end

    // Purpose: summary interrupt while any error flag is held.
    always_comb err_irq = |err_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
        AST_CREDIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_fifo_full[i] && ch_credit[i*CREDIT_W +: CREDIT_W] != '0) |=> err_q[CRED_LSB+i]); // R3
        AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_act_cmd[i] && ch_req_busy[i]) |=> err_q[OVR_LSB+i]);                           // R4
    end
    AST_HOST_SET:  assert property (@(posedge clk) disable iff (!rst_n)
        host_cnt_err |=> err_q[HOST_BIT]);                                                     // R5
    AST_ADDR_SET:  assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr_err |=> err_q[ADDR_BIT]);                                                     // R6
    AST_IRQ_RISE:  assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq) |-> $past(set_vec != '0));                                              // R9
    AST_IRQ_FALL:  assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_irq) |-> $past(reg_wr && reg_addr == ADDR_W'(WA_ERROR)));                    // R9
    AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(WA_STATUS)) |-> (reg_rdata[15:0] == 16'h0));                      // R1
    AST_ERR_RSVD:  assert property (@(posedge clk) disable iff (!rst_n)
        (err_q & ~ERR_MASK) == '0);                                                            // R10
endmodule

// File: tb/txs_shared_regs_bench.sv
module txs_shared_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int CW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] ch_buf_empty = '0, ch_no_pend = '0, ch_fifo_full = '0;
    logic [NCH-1:0] ch_act_cmd = '0, ch_req_busy = '0;
    logic [NCH*CW-1:0] ch_credit = '0;
    logic host_cnt_err = 1'b0, mem_addr_err = 1'b0;
    logic [1:0] reg_addr = '0;
    logic reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic err_irq;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] exp_err = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txs_shared_regs u_txs_shared_regs (
        .clk(clk), .rst_n(rst_n), .ch_buf_empty(ch_buf_empty), .ch_no_pend(ch_no_pend),
        .ch_fifo_full(ch_fifo_full), .ch_credit(ch_credit), .ch_act_cmd(ch_act_cmd),
        .ch_req_busy(ch_req_busy), .host_cnt_err(host_cnt_err), .mem_addr_err(mem_addr_err),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_irq(err_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock edge; inputs change and outputs are sampled at negedges
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_err(input string req);
        reg_addr = 2'd1;
        #1;
        check(req, reg_rdata, exp_err);
        check({req, " R9 irq"}, {31'd0, err_irq}, {31'd0, exp_err != 0});
    endtask

    task automatic clear_all();
        reg_addr = 2'd1; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
        exp_err = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        check_err("R11 reset");
        rst_n = 1'b1;
        step();
        check_err("R11 after release");

        // R1 R2: status word sweep
        reg_addr = 2'd0;
        for (int v = 0; v < 256; v++) begin
            ch_buf_empty = 8'(v);
            ch_no_pend   = 8'(v * 37 + 11);
            #1;
            check("R1 R2 status", reg_rdata, {ch_buf_empty, ch_no_pend, 16'h0});
        end

        // R3: credit check sweep over channels and credit values
        for (int ch = 0; ch < NCH; ch++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] cv;
                cv = (k == 0) ? 8'd0 : (k == 1) ? 8'd1 : (k == 2) ? 8'd77 : 8'd255;
                ch_credit = '0;
                ch_credit[ch*CW +: CW] = cv;
                ch_fifo_full[ch] = 1'b1;
                step();
                ch_fifo_full = '0;
                if (cv != 0) exp_err[ch] = 1'b1;
                check_err("R3 credit");
                clear_all();
                check_err("R7 clear after R3");
            end
        end
        ch_credit = '0;

        // R4: overrun sweep with busy on and off
        for (int ch = 0; ch < NCH; ch++) begin
            for (int b = 0; b < 2; b++) begin
                ch_req_busy = '0;
                ch_req_busy[ch] = b[0];
                ch_act_cmd[ch] = 1'b1;
                step();
                ch_act_cmd = '0;
                if (b == 1) exp_err[9+ch] = 1'b1;
                check_err("R4 overrun");
                clear_all();
            end
        end
        ch_req_busy = '0;

        // R5 R6
        host_cnt_err = 1'b1; step(); host_cnt_err = 1'b0;
        exp_err[30] = 1'b1; check_err("R5 host");
        mem_addr_err = 1'b1; step(); mem_addr_err = 1'b0;
        exp_err[31] = 1'b1; check_err("R6 addr");

        // R7: writing zero keeps bits; partial write-one clears only those
        reg_addr = 2'd1; reg_wr = 1'b1; reg_wdata = 32'h0; step(); reg_wr = 1'b0;
        check_err("R7 write zero");
        reg_wr = 1'b1; reg_wdata = 32'h4000_0000; step(); reg_wr = 1'b0;
        exp_err[30] = 1'b0; check_err("R7 partial clear");

        // R10: writes to other addresses leave the error word alone; reserved bits
        for (int a = 0; a < 4; a++) begin
            if (a == 1) continue;
            reg_addr = 2'(a); reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; step(); reg_wr = 1'b0;
            check_err("R10 foreign write");
        end
        reg_addr = 2'd2; #1; check("R10 addr2", reg_rdata, 32'h0);
        reg_addr = 2'd3; #1; check("R10 addr3", reg_rdata, 32'h0);
        clear_all();

        // R8: set and clear on the same edge, plus all events at once
        ch_credit = {NCH{8'd3}};
        ch_fifo_full = 8'hA5; ch_act_cmd = 8'h3C; ch_req_busy = 8'hFF;
        host_cnt_err = 1'b1; mem_addr_err = 1'b1;
        reg_addr = 2'd1; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF;
        step();
        reg_wr = 1'b0; ch_fifo_full = '0; ch_act_cmd = '0; host_cnt_err = 1'b0; mem_addr_err = 1'b0;
        exp_err = 32'hC000_0000 | (32'h3C << 9) | 32'hA5;
        check_err("R8 set wins");
        check("R10 reserved bits", reg_rdata & 32'h3FFE_0100, 32'h0);
        clear_all();
        check_err("R9 irq low after clear");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule